// File: doc/BRIEF.md
# Single-Cycle 8-bit CPU Core with Hardware Return Stack

This block is a small processor that executes one fixed 16-bit instruction per clock. Its arithmetic datapath and sixteen general registers are 8 bits wide. Its program counter is 10 bits wide, so 1024 instruction words can be reached directly. The instruction word is read combinationally from an instruction memory addressed by the program counter. Stores drive an 8-bit address, 8-bit data and a write strobe toward data memory or memory-mapped I/O.

Subroutine linkage uses a private 16-entry stack of 10-bit return addresses. It never touches data memory. A call pushes and redirects in the same cycle, and a return pops straight into the program counter. Pushing onto a full stack or popping an empty one raises a sticky fault output. The stack pointer does not move, and execution carries on at the next sequential word.

Instruction encoding (opcode in bits [15:12]): 0 no-op; 1 load immediate (rd=[11:8], value=[7:0]); 2 store (source=[11:8], address=[7:0]); 3 add (rd=[11:8], ra=[7:4], rb=[3:0]); 4 decrement (rd=[11:8]); 5 compare (ra=[7:4], rb=[3:0]); 6 jump; 7 branch; 8 call; 9 return. Jump, branch and call take a 10-bit target from [9:0]. Branch selects its condition with [11:10]: 00 zero set, 01 zero clear, 10 carry set, 11 carry clear. Opcodes 10 to 15 behave as no-ops.

Top module: `rs_cpu`

## Requirements
- R1: When rst_ni is low, the program counter, stack pointer, zero and carry flags, fault output and all sixteen registers are cleared. The first fetch after reset is from address 0.
- R2: Load immediate writes [7:0] into rd. Store asserts dmem_we_o for exactly that instruction's cycle, with dmem_addr_o=[7:0] and dmem_wdata_o equal to the source register.
- R3: Add writes the 8-bit sum of ra and rb to rd. It sets carry to the carry out of bit 7 and zero when the 8-bit result is 0. Load, store, jump and branch leave both flags unchanged.
- R4: Decrement writes rd-1 modulo 256 to rd. Zero is set when the result is 0, and carry is set when rd was 0 before the instruction (borrow).
- R5: Compare computes ra-rb and leaves every register unchanged. It sets zero when ra equals rb and carry when ra is less than rb (unsigned).
- R6: Jump loads the program counter with the 10-bit target.
- R7: Branch loads the target when its selected condition (00 zero, 01 not zero, 10 carry, 11 not carry) holds. Otherwise it advances to the next word.
- R8: Call pushes the current program counter plus one, modulo 1024, and jumps to the target. Return pops the most recent entry into the program counter. Sixteen calls can nest without a fault.
- R9: A call made while 16 entries are in use sets the sticky fault output. It leaves the stack unchanged and does not jump; execution continues at the next word.
- R10: A return made with an empty stack sets the sticky fault output, leaves the stack pointer at zero and continues at the next word. The fault clears only on reset.
- R11: Sequential execution wraps the program counter from 1023 to 0. A call at address 1023 pushes return address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 10 | Instruction fetch address (program counter) |
| imem_data_i | input | 16 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 8 | Data write address |
| dmem_wdata_o | output | 8 | Data write value |
| dmem_we_o | output | 1 | Data write strobe, one cycle per store |
| fault_o | output | 1 | Sticky return-stack overflow or underflow |

## Verification
Every instruction completes in its own cycle. A store appears on the data port during the cycle it is fetched and lands in the bench memory at that cycle's closing edge. Register, flag, stack and program-counter updates become visible at the next fetch, one edge later. Flags and registers can only be seen through stores and branch outcomes, so each test is a short program that ends in a self-jump. The bench runs it for a fixed margin of cycles well beyond its longest path, then samples memory, fetch address and fault at a falling edge.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int INSTR_W = 16;

  localparam logic [3:0] OP_NOP = 4'd0;
  localparam logic [3:0] OP_LDI = 4'd1;
  localparam logic [3:0] OP_STR = 4'd2;
  localparam logic [3:0] OP_ADD = 4'd3;
  localparam logic [3:0] OP_DEC = 4'd4;
  localparam logic [3:0] OP_CMP = 4'd5;
  localparam logic [3:0] OP_JMP = 4'd6;
  localparam logic [3:0] OP_BRH = 4'd7;
  localparam logic [3:0] OP_CAL = 4'd8;
  localparam logic [3:0] OP_RET = 4'd9;

  typedef enum logic [1:0] {CC_Z = 2'd0, CC_NZ = 2'd1, CC_C = 2'd2, CC_NC = 2'd3} cond_e;
  typedef enum logic {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_op_e;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] rd;
    logic [3:0] ra;
    logic [3:0] rb;
  } instr_t;
endpackage

// File: rtl/rs_regfile.sv
module rs_regfile #(
  parameter int DATA_W = 8,
  parameter int REG_N  = 16,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  raddr_a_i,
  input  logic [IDX_W-1:0]  raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] reg_q [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 reg_q[g] <= '0;
      else if (we_i && (waddr_i == IDX_W'(g)))     reg_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = reg_q[raddr_a_i];
  assign rdata_b_o = reg_q[raddr_b_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> reg_q[$past(waddr_i)] == $past(wdata_i)); // R2
endmodule

// File: rtl/rs_alu.sv
module rs_alu
  import rs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o,
  output logic              zero_o,
  output logic              carry_o
);
  logic [DATA_W:0] wide;

  always_comb begin
    if (op_i == ALU_ADD) wide = {1'b0, a_i} + {1'b0, b_i};
    else                 wide = {1'b0, a_i} - {1'b0, b_i};  // msb = borrow
  end

  assign y_o     = wide[DATA_W-1:0];
  assign carry_o = wide[DATA_W];
  assign zero_o  = (y_o == '0);

  always_comb begin
    if (op_i == ALU_SUB)
      AST_SUB_BORROW: assert (carry_o == (a_i < b_i)); // R5
  end
endmodule

// File: rtl/rs_retstack.sv
module rs_retstack #(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_data_i,
  output logic [ADDR_W-1:0] top_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              fault_o
);
  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  sp_q;
  logic              fault_q;
  logic              push_ok, pop_ok;
  logic [IDX_W-1:0]  idx_wr, idx_top;

  assign full_o  = (sp_q == PTR_W'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign idx_wr  = sp_q[IDX_W-1:0];
  assign idx_top = IDX_W'(sp_q - 1'b1);
  assign top_o   = slot_q[idx_top];
  assign fault_o = fault_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) slot_q[idx_wr] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      if (push_ok)     sp_q <= sp_q + 1'b1;
      else if (pop_ok) sp_q <= sp_q - 1'b1;
      if ((push_i && full_o) || (pop_i && empty_o)) fault_q <= 1'b1;
    end
  end

  always_comb begin
    if (rst_ni) AST_SP_BOUND: assert (sp_q <= PTR_W'(DEPTH)); // R8
  end

  AST_LIFO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok |=> top_o == $past(push_data_i)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> $stable(sp_q) && fault_o); // R9
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> (sp_q == '0) && fault_o); // R10
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o); // R10
endmodule

// File: rtl/rs_cpu.sv
module rs_cpu
  import rs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PC_W    = 10,
  parameter int REG_N   = 16,
  parameter int STACK_D = 16,
  parameter int DADDR_W = 8,
  localparam int IDX_W  = $clog2(REG_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [PC_W-1:0]    imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  output logic [DADDR_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0]  dmem_wdata_o,
  output logic               dmem_we_o,
  output logic               fault_o
);
  instr_t            ins;
  cond_e             cc;
  logic [PC_W-1:0]   pc_q, pc_next, pc_plus, tgt;
  logic [DATA_W-1:0] imm;
  logic              flag_z_q, flag_c_q;

  logic [IDX_W-1:0]  rf_ra;
  logic [DATA_W-1:0] rf_da, rf_db, rf_wd;
  logic              rf_we;

  alu_op_e           alu_op;
  logic [DATA_W-1:0] alu_b, alu_y;
  logic              alu_z, alu_c, flag_we;

  logic              stk_full, stk_empty;
  logic [PC_W-1:0]   stk_top;
  logic              br_take;

  assign ins     = instr_t'(imem_data_i);
  assign cc      = cond_e'(imem_data_i[11:10]);
  assign tgt     = imem_data_i[PC_W-1:0];
  assign imm     = imem_data_i[7:0];
  assign pc_plus = pc_q + 1'b1;

  // operand A comes from ra for two-source ops, else from the rd field
  assign rf_ra  = (ins.op == OP_ADD || ins.op == OP_CMP) ? ins.ra : ins.rd;
  assign alu_op = (ins.op == OP_ADD) ? ALU_ADD : ALU_SUB;
  assign alu_b  = (ins.op == OP_DEC) ? DATA_W'(1) : rf_db;

  assign rf_we   = (ins.op == OP_LDI) || (ins.op == OP_ADD) || (ins.op == OP_DEC);
  assign rf_wd   = (ins.op == OP_LDI) ? DATA_W'(imm) : alu_y;
  assign flag_we = (ins.op == OP_ADD) || (ins.op == OP_DEC) || (ins.op == OP_CMP);

  rs_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (rf_ra),
    .raddr_b_i (ins.rb),
    .rdata_a_o (rf_da),
    .rdata_b_o (rf_db),
    .we_i      (rf_we),
    .waddr_i   (ins.rd),
    .wdata_i   (rf_wd)
  );

  rs_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (alu_op),
    .a_i     (rf_da),
    .b_i     (alu_b),
    .y_o     (alu_y),
    .zero_o  (alu_z),
    .carry_o (alu_c)
  );

  rs_retstack #(.ADDR_W(PC_W), .DEPTH(STACK_D)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ins.op == OP_CAL),
    .pop_i       (ins.op == OP_RET),
    .push_data_i (pc_plus),
    .top_o       (stk_top),
    .full_o      (stk_full),
    .empty_o     (stk_empty),
    .fault_o     (fault_o)
  );

  always_comb begin
    unique case (cc)
      CC_Z:    br_take = flag_z_q;
      CC_NZ:   br_take = !flag_z_q;
      CC_C:    br_take = flag_c_q;
      default: br_take = !flag_c_q;
    endcase
  end

  always_comb begin
    case (ins.op)
      OP_JMP:  pc_next = tgt;
      OP_BRH:  pc_next = br_take ? tgt : pc_plus;
      OP_CAL:  pc_next = stk_full ? pc_plus : tgt;
      OP_RET:  pc_next = stk_empty ? pc_plus : stk_top;
      default: pc_next = pc_plus;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      flag_z_q <= 1'b0;
      flag_c_q <= 1'b0;
    end else begin
      pc_q <= pc_next;
      if (flag_we) begin
        flag_z_q <= alu_z;
        flag_c_q <= alu_c;
      end
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_we_o    = (ins.op == OP_STR);
  assign dmem_addr_o  = DADDR_W'(imm);
  assign dmem_wdata_o = rf_da;

  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins.op == OP_LDI || ins.op == OP_STR || ins.op == OP_ADD || ins.op == OP_NOP)
    |=> imem_addr_o == PC_W'($past(imem_addr_o) + 1'b1)); // R11
  AST_JMP_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins.op == OP_JMP) |=> imem_addr_o == $past(imem_data_i[PC_W-1:0])); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins.op == OP_LDI || ins.op == OP_STR || ins.op == OP_JMP || ins.op == OP_BRH)
    |=> $stable(flag_z_q) && $stable(flag_c_q)); // R3
  AST_CALL_FULL_NOJUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins.op == OP_CAL && stk_full) |=> imem_addr_o == PC_W'($past(imem_addr_o) + 1'b1)); // R9
endmodule

// File: tb/rs_cpu_test.sv
module rs_cpu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  imem_addr;
  logic [15:0] imem_data;
  logic [7:0]  dmem_addr, dmem_wdata;
  logic        dmem_we, fault;
  logic        clr = 1'b0;

  logic [15:0] imem [1024];
  logic [7:0]  dmem [256];
  int          wr_cnt;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rs_cpu uut (
    .clk_i(clk), .rst_ni(rst_n), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata), .dmem_we_o(dmem_we), .fault_o(fault)
  );

  assign imem_data = imem[imem_addr];

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) dmem[i] <= 8'hAA;
      wr_cnt <= 0;
    end else if (dmem_we) begin
      dmem[dmem_addr] <= dmem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [15:0] e_ldi(input logic [3:0] rd, input logic [7:0] v); return {4'h1, rd, v}; endfunction
  function automatic logic [15:0] e_str(input logic [3:0] rs, input logic [7:0] a); return {4'h2, rs, a}; endfunction
  function automatic logic [15:0] e_add(input logic [3:0] rd, input logic [3:0] ra, input logic [3:0] rb); return {4'h3, rd, ra, rb}; endfunction
  function automatic logic [15:0] e_dec(input logic [3:0] rd); return {4'h4, rd, 8'h00}; endfunction
  function automatic logic [15:0] e_cmp(input logic [3:0] ra, input logic [3:0] rb); return {4'h5, 4'h0, ra, rb}; endfunction
  function automatic logic [15:0] e_jmp(input logic [9:0] t); return {4'h6, 2'b00, t}; endfunction
  function automatic logic [15:0] e_brh(input logic [1:0] c, input logic [9:0] t); return {4'h7, c, t}; endfunction
  function automatic logic [15:0] e_cal(input logic [9:0] t); return {4'h8, 2'b00, t}; endfunction
  function automatic logic [15:0] e_ret(); return 16'h9000; endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 1024; i++) imem[i] = 16'h0000;
  endtask

  // reset with memory clear; releases at a falling edge
  task automatic restart();
    rst_n = 1'b0;
    clr = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {4'b0, op[1:0] (0 add,1 dec,2 cmp), z, c, a, b, result}
  localparam logic [31:0] VEC [10] = '{
    {4'h0, 2'd0, 1'b0, 1'b0, 8'd5,   8'd3,   8'd8},
    {4'h0, 2'd0, 1'b0, 1'b1, 8'd200, 8'd100, 8'd44},
    {4'h0, 2'd0, 1'b1, 1'b1, 8'd128, 8'd128, 8'd0},
    {4'h0, 2'd0, 1'b1, 1'b0, 8'd0,   8'd0,   8'd0},
    {4'h0, 2'd1, 1'b1, 1'b0, 8'd1,   8'd0,   8'd0},
    {4'h0, 2'd1, 1'b0, 1'b1, 8'd0,   8'd0,   8'd255},
    {4'h0, 2'd1, 1'b0, 1'b0, 8'd77,  8'd0,   8'd76},
    {4'h0, 2'd2, 1'b1, 1'b0, 8'd9,   8'd9,   8'd9},
    {4'h0, 2'd2, 1'b0, 1'b1, 8'd3,   8'd7,   8'd3},
    {4'h0, 2'd2, 1'b0, 1'b0, 8'd7,   8'd3,   8'd7}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, registers read as zero
    wipe();
    imem[0] = e_str(4'd7, 8'h30);
    imem[1] = e_jmp(10'd1);
    rst_n = 1'b0;
    clr = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", imem_addr, 0);
    chk("R1 fault in reset", fault, 0);
    clr = 1'b0;
    rst_n = 1'b1;
    run(10);
    chk("R1 register zero after reset", dmem[8'h30], 0);
    chk("R2 single store strobe", wr_cnt, 1);

    // R3 R4 R5 R7 table walk: result store and flag probe via branches
    for (int v = 0; v < 10; v++) begin
      logic [1:0] op;
      logic [7:0] a, b, res;
      logic       z, c;
      {op, z, c, a, b, res} = VEC[v][27:0];
      wipe();
      imem[0]  = e_ldi(4'd1, a);
      imem[1]  = e_ldi(4'd2, b);
      imem[2]  = (op == 2'd0) ? e_add(4'd3, 4'd1, 4'd2) :
                 (op == 2'd1) ? e_dec(4'd1) : e_cmp(4'd1, 4'd2);
      imem[3]  = e_str((op == 2'd0) ? 4'd3 : 4'd1, 8'h20);
      imem[4]  = e_ldi(4'd4, 8'd0);
      imem[5]  = e_brh(2'd0, 10'd7);
      imem[6]  = e_jmp(10'd8);
      imem[7]  = e_ldi(4'd4, 8'd1);
      imem[8]  = e_brh(2'd2, 10'd10);
      imem[9]  = e_jmp(10'd12);
      imem[10] = e_ldi(4'd5, 8'd2);
      imem[11] = e_add(4'd4, 4'd4, 4'd5);
      imem[12] = e_str(4'd4, 8'h21);
      imem[13] = e_jmp(10'd13);
      restart();
      run(40);
      chk($sformatf("R3/R4/R5 vector %0d result", v), dmem[8'h20], res);
      chk($sformatf("R3/R4/R5 vector %0d flags {c,z}", v), dmem[8'h21], {6'b0, c, z});
    end

    // R7: not-zero taken, not-carry not taken (3 vs 7) and taken (7 vs 3)
    for (int k = 0; k < 2; k++) begin
      wipe();
      imem[0]  = e_ldi(4'd1, (k == 0) ? 8'd3 : 8'd7);
      imem[1]  = e_ldi(4'd2, (k == 0) ? 8'd7 : 8'd3);
      imem[2]  = e_cmp(4'd1, 4'd2);
      imem[3]  = e_ldi(4'd4, 8'd0);
      imem[4]  = e_brh(2'd1, 10'd6);
      imem[5]  = e_jmp(10'd7);
      imem[6]  = e_ldi(4'd4, 8'd1);
      imem[7]  = e_brh(2'd3, 10'd9);
      imem[8]  = e_jmp(10'd10);
      imem[9]  = e_ldi(4'd4, 8'd9);
      imem[10] = e_str(4'd4, 8'h40);
      imem[11] = e_jmp(10'd11);
      restart();
      run(30);
      chk($sformatf("R7 not-zero/not-carry case %0d", k), dmem[8'h40], (k == 0) ? 1 : 9);
    end

    // R8 R6: simple call and return
    wipe();
    imem[0] = e_cal(10'd5);
    imem[1] = e_ldi(4'd1, 8'h11);
    imem[2] = e_str(4'd1, 8'h50);
    imem[3] = e_jmp(10'd3);
    imem[5] = e_ldi(4'd2, 8'h22);
    imem[6] = e_str(4'd2, 8'h51);
    imem[7] = e_ret();
    restart();
    run(20);
    chk("R8 subroutine body ran", dmem[8'h51], 8'h22);
    chk("R8 returned to caller", dmem[8'h50], 8'h11);
    chk("R6 parked on self jump", imem_addr, 3);
    chk("R8 no fault", fault, 0);

    // R8 R9: recursion of depth 16 (no fault) and 17 (overflow)
    for (int k = 0; k < 2; k++) begin
      wipe();
      imem[0]  = e_ldi(4'd1, (k == 0) ? 8'd16 : 8'd17);
      imem[1]  = e_ldi(4'd3, 8'd0);
      imem[2]  = e_cal(10'd10);
      imem[3]  = e_str(4'd3, 8'h60);
      imem[4]  = e_jmp(10'd4);
      imem[10] = e_dec(4'd1);
      imem[11] = e_brh(2'd0, 10'd13);
      imem[12] = e_cal(10'd10);
      imem[13] = e_ldi(4'd5, 8'd1);
      imem[14] = e_add(4'd3, 4'd3, 4'd5);
      imem[15] = e_ret();
      restart();
      run(300);
      if (k == 0) begin
        chk("R8 sixteen nested returns", dmem[8'h60], 16);
        chk("R8 depth 16 no fault", fault, 0);
      end else begin
        chk("R9 overflow levels unwound", dmem[8'h60], 16);
        chk("R9 overflow fault", fault, 1);
        chk("R9 back in main loop", imem_addr, 4);
        run(20);
        chk("R9 fault sticky", fault, 1);
      end
    end

    // R10: return on empty stack, then stack still usable
    wipe();
    imem[0] = e_ret();
    imem[1] = e_ldi(4'd1, 8'h33);
    imem[2] = e_str(4'd1, 8'h70);
    imem[3] = e_cal(10'd6);
    imem[4] = e_str(4'd1, 8'h71);
    imem[5] = e_jmp(10'd5);
    imem[6] = e_ret();
    restart();
    run(20);
    chk("R10 underflow falls through", dmem[8'h70], 8'h33);
    chk("R10 pointer held at zero", dmem[8'h71], 8'h33);
    chk("R10 underflow fault", fault, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears fault", fault, 0);
    chk("R1 reset clears pc", imem_addr, 0);
    rst_n = 1'b1;

    // R11: call at 1023 returns to 0
    wipe();
    imem[0]    = e_dec(4'd6);
    imem[1]    = e_brh(2'd3, 10'd4);
    imem[2]    = e_jmp(10'd1023);
    imem[4]    = e_str(4'd6, 8'h80);
    imem[5]    = e_jmp(10'd5);
    imem[1010] = e_ret();
    imem[1023] = e_cal(10'd1010);
    restart();
    run(30);
    chk("R11 call at 1023 returns to 0", dmem[8'h80], 254);

    // R11: sequential wrap from 1023
    imem[1023] = e_ldi(4'd7, 8'h5A);
    imem[4]    = e_str(4'd7, 8'h81);
    restart();
    run(30);
    chk("R11 sequential wrap", dmem[8'h81], 8'h5A);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule